// File: doc/BRIEF.md
# Same-Sign Single-Precision Floating-Point Adder

This block adds two 32-bit binary floating-point words that carry the same sign. Each word has a sign bit, an 8-bit exponent biased by 127 and a 23-bit fraction. The datapath has four stages of logic. It splits each operand into its fields and puts the hidden leading one back in front of the fraction. It then shifts the mantissa of the operand with the smaller exponent right until both exponents match. It adds the two mantissas and corrects the result when the sum carries past the integer bit. Last, it rounds to the nearest value, ties going to even, and packs the fields into a result word. One register stage holds the result, the overflow flag and the unsupported flag, so an answer appears one clock after its operands.

Some inputs bypass the datapath. A NaN operand yields the canonical quiet NaN. An infinite operand is returned as it is. An operand whose exponent field is zero counts as zero, and the other operand is returned bit for bit. Operands with different signs would need a subtractor, which this block does not contain. They raise the unsupported flag instead.

Top module: `fp32_same_sign_adder`

## Requirements
- R1: For two same-sign operands whose exponent fields are both in 1..254, the result is registered one clock after the operands are applied and equals their sum rounded to 23 fraction bits. The result keeps the operands' sign. Example: 0x3FC00000 + 0x40500000 gives 0x40980000.
- R2: The mantissa of the operand with the smaller exponent is shifted right by the difference of the exponents. The result therefore does not depend on which port carries which operand.
- R3: When the mantissa sum carries past the integer bit, the sum is shifted right by one and the exponent goes up by one. Example: 0x3FC00000 + 0x3FC00000 gives 0x40400000.
- R4: Rounding uses guard, round and sticky bits kept through alignment. A value exactly halfway between two results rounds to the one with an even last fraction bit: 0x3F800000 + 0x33800000 gives 0x3F800000, and 0x3F800001 + 0x33800000 gives 0x3F800002.
- R5: When rounding up carries out of the mantissa, the result is renormalized: 0x3FFFFFFF + 0x33800000 gives 0x40000000.
- R6: If the final exponent reaches 255, the result is infinity with the operands' sign (exponent field 0xFF, fraction 0) and `overflow` is 1. In every other case `overflow` is 0.
- R7: If either operand is NaN (exponent field 0xFF, nonzero fraction), the result is 0x7FC00000.
- R8: If neither operand is NaN, the signs match and an operand is infinite (exponent field 0xFF, fraction 0), that operand is returned. Operand A is returned when both are infinite.
- R9: If no operand is NaN or infinite and the signs match, an operand whose exponent field is 0 counts as zero and the other operand is returned unchanged. Operand B is returned when both exponent fields are 0.
- R10: If the sign bits (bit 31) differ, `unsupported` is 1 and the result is 0x7FC00000. Otherwise `unsupported` is 0.
- R11: While `rst_n` is low, the result and both flags are 0.
- R12: When the exponents differ by 25 or more, the larger operand is returned unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_a | input | 32 | First operand |
| op_b | input | 32 | Second operand |
| result | output | 32 | Registered sum or special value |
| overflow | output | 1 | Sum exceeded the largest finite value |
| unsupported | output | 1 | Operand signs differ |

## Verification
The hardest cases to reach from the ports are exact ties and the rounding carry. A tie needs an exponent gap and fraction bits that leave exactly one half unit in the last place below the kept bits. The rounding carry needs an all-ones mantissa on top of that. Uniformly random operands almost never produce either case. The stimulus therefore includes directed pairs that use a 24-step exponent gap against 1.0 and against 1.0 plus one unit. Random pairs are kept within about 30 exponent steps of each other, so the guard and sticky bits see a wide spread of values. Exponents near 254 are also weighted so that overflow occurs often.

// File: rtl/fpadd_pkg.sv
package fpadd_pkg;
  localparam int DEF_EXP_W  = 8;
  localparam int DEF_FRAC_W = 23;
  localparam int GRS_W      = 3;   // guard, round, sticky

  typedef enum logic [2:0] {
    SEL_QNAN,
    SEL_PASS_A,
    SEL_PASS_B,
    SEL_OVF,
    SEL_SUM
  } sel_e;
endpackage

// File: rtl/fpadd_classify.sv
module fpadd_classify #(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23
) (
  input  logic [EXP_W+FRAC_W:0] word,
  output logic                  sign,
  output logic [EXP_W-1:0]      exp_f,
  output logic [FRAC_W:0]       mant,
  output logic                  is_zero,
  output logic                  is_inf,
  output logic                  is_nan
);
  logic [FRAC_W-1:0] frac;
  logic              exp_max;

  assign sign    = word[EXP_W+FRAC_W];
  assign exp_f   = word[EXP_W+FRAC_W-1:FRAC_W];
  assign frac    = word[FRAC_W-1:0];
  assign exp_max = &exp_f;
  assign is_zero = (exp_f == '0);
  assign is_inf  = exp_max && (frac == '0);
  assign is_nan  = exp_max && (frac != '0);
  // hidden one restored for every operand outside the zero class
  assign mant    = {~is_zero, frac};
endmodule

// File: rtl/fpadd_align.sv
module fpadd_align #(
  parameter int MW    = 24,
  parameter int GRS   = 3,
  parameter int EXP_W = 8
) (
  input  logic [MW-1:0]     mant_in,
  input  logic [EXP_W-1:0]  shift,
  output logic [MW+GRS-1:0] aligned
);
  localparam int XW = MW + GRS;

  logic [XW-1:0] ext;
  logic [XW-1:0] shifted;
  logic [XW-1:0] lost_mask;
  logic          sticky;

  assign ext = {mant_in, {GRS{1'b0}}};

  always_comb begin
    if (32'(shift) >= XW) begin
      shifted   = '0;
      lost_mask = '1;
    end else begin
      shifted   = ext >> shift;
      lost_mask = ~({XW{1'b1}} << shift);
    end
    sticky  = |(ext & lost_mask);
    aligned = shifted | {{(XW-1){1'b0}}, sticky};
  end
endmodule

// File: rtl/fpadd_normround.sv
module fpadd_normround #(
  parameter int MW    = 24,
  parameter int GRS   = 3,
  parameter int EXP_W = 8
) (
  input  logic [MW+GRS:0]  raw_sum,
  input  logic [EXP_W-1:0] exp_in,
  output logic [MW-2:0]    frac_out,
  output logic [EXP_W:0]   exp_out,
  output logic             carry_shift,
  output logic             round_carry
);
  localparam int XW = MW + GRS;

  logic [XW-1:0] norm;
  logic [EXP_W:0] exp_norm;
  logic [MW-1:0] kept;
  logic          guard, rest, round_up;
  logic [MW:0]   rounded;

  assign carry_shift = raw_sum[XW];
  assign norm     = carry_shift ? {raw_sum[XW:2], |raw_sum[1:0]} : raw_sum[XW-1:0];
  assign exp_norm = {1'b0, exp_in} + {{EXP_W{1'b0}}, carry_shift};

  assign kept     = norm[XW-1:GRS];
  assign guard    = norm[GRS-1];
  assign rest     = |norm[GRS-2:0];
  assign round_up = guard && (rest || kept[0]);
  assign rounded  = {1'b0, kept} + {{MW{1'b0}}, round_up};

  assign round_carry = rounded[MW];
  assign frac_out    = round_carry ? '0 : rounded[MW-2:0];
  assign exp_out     = exp_norm + {{EXP_W{1'b0}}, round_carry};
endmodule

// File: rtl/fp32_same_sign_adder.sv
module fp32_same_sign_adder
  import fpadd_pkg::*;
#(
  parameter int EXP_W  = DEF_EXP_W,
  parameter int FRAC_W = DEF_FRAC_W
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [EXP_W+FRAC_W:0]   op_a,
  input  logic [EXP_W+FRAC_W:0]   op_b,
  output logic [EXP_W+FRAC_W:0]   result,
  output logic                    overflow,
  output logic                    unsupported
);
  localparam int WORD_W = 1 + EXP_W + FRAC_W;
  localparam int MW     = FRAC_W + 1;
  localparam int XW     = MW + GRS_W;
  localparam logic [EXP_W-1:0]  EXP_ONES = '1;
  localparam logic [WORD_W-1:0] QNAN =
    {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};

  logic [WORD_W-1:0] opnd [2];
  logic [1:0]        sgn, zer, inf, nan;
  logic [EXP_W-1:0]  ex [2];
  logic [MW-1:0]     mt [2];

  assign opnd[0] = op_a;
  assign opnd[1] = op_b;

  for (genvar gi = 0; gi < 2; gi++) begin : g_cls
    fpadd_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_cls (
      .word   (opnd[gi]),
      .sign   (sgn[gi]),
      .exp_f  (ex[gi]),
      .mant   (mt[gi]),
      .is_zero(zer[gi]),
      .is_inf (inf[gi]),
      .is_nan (nan[gi])
    );
  end

  // operand ordering by exponent
  logic             a_big;
  logic [EXP_W-1:0] big_exp, small_exp, shift_amt;
  logic [MW-1:0]    big_mant, small_mant;
  logic [XW-1:0]    aligned;
  logic [XW:0]      raw_sum;

  assign a_big      = ex[0] >= ex[1];
  assign big_exp    = a_big ? ex[0] : ex[1];
  assign small_exp  = a_big ? ex[1] : ex[0];
  assign big_mant   = a_big ? mt[0] : mt[1];
  assign small_mant = a_big ? mt[1] : mt[0];
  assign shift_amt  = big_exp - small_exp;

  fpadd_align #(.MW(MW), .GRS(GRS_W), .EXP_W(EXP_W)) u_align (
    .mant_in(small_mant),
    .shift  (shift_amt),
    .aligned(aligned)
  );

  assign raw_sum = {1'b0, big_mant, {GRS_W{1'b0}}} + {1'b0, aligned};

  logic [FRAC_W-1:0] frac_n;
  logic [EXP_W:0]    exp_n;
  logic              carry_shift, round_carry;

  fpadd_normround #(.MW(MW), .GRS(GRS_W), .EXP_W(EXP_W)) u_round (
    .raw_sum    (raw_sum),
    .exp_in     (big_exp),
    .frac_out   (frac_n),
    .exp_out    (exp_n),
    .carry_shift(carry_shift),
    .round_carry(round_carry)
  );

  // named events for checking
  logic mismatch, any_nan, any_inf, overflow_hit, path_normal;
  sel_e sel;

  assign mismatch     = sgn[0] ^ sgn[1];
  assign any_nan      = |nan;
  assign any_inf      = |inf;
  assign overflow_hit = exp_n >= {1'b0, EXP_ONES};

  always_comb begin
    if (any_nan || mismatch)  sel = SEL_QNAN;
    else if (inf[0])          sel = SEL_PASS_A;
    else if (inf[1])          sel = SEL_PASS_B;
    else if (zer[0])          sel = SEL_PASS_B;
    else if (zer[1])          sel = SEL_PASS_A;
    else if (overflow_hit)    sel = SEL_OVF;
    else                      sel = SEL_SUM;
  end

  assign path_normal = (sel == SEL_SUM) || (sel == SEL_OVF);

  logic [WORD_W-1:0] res_nxt;
  always_comb begin
    unique case (sel)
      SEL_QNAN:   res_nxt = QNAN;
      SEL_PASS_A: res_nxt = op_a;
      SEL_PASS_B: res_nxt = op_b;
      SEL_OVF:    res_nxt = {sgn[0], EXP_ONES, {FRAC_W{1'b0}}};
      default:    res_nxt = {sgn[0], exp_n[EXP_W-1:0], frac_n};
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result      <= '0;
      overflow    <= 1'b0;
      unsupported <= 1'b0;
    end else begin
      result      <= res_nxt;
      overflow    <= (sel == SEL_OVF);
      unsupported <= mismatch;
    end
  end

  // R10: differing signs flag and give canonical NaN
  a_r10_mismatch_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (op_a[WORD_W-1] != op_b[WORD_W-1]) |=> (unsupported && result == QNAN));

  // R7: NaN input gives canonical NaN, never overflow
  a_r7_nan_canon: assert property (@(posedge clk) disable iff (!rst_n)
    any_nan |=> (result == QNAN && !overflow));

  // R6: overflow flag only with an infinity result
  a_r6_overflow_inf: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |-> (result[WORD_W-2:0] == {EXP_ONES, {FRAC_W{1'b0}}}));

  // R3: a same-sign sum never has a smaller exponent than the larger operand
  a_r3_exp_monotone: assert property (@(posedge clk) disable iff (!rst_n)
    path_normal |=> (result[WORD_W-2:FRAC_W] >= $past(big_exp)));

  // R1: sign carried through the arithmetic path
  a_r1_sign_kept: assert property (@(posedge clk) disable iff (!rst_n)
    path_normal |=> (result[WORD_W-1] == $past(op_a[WORD_W-1])));

  // R9: zero-class A passes B unchanged
  a_r9_zero_pass: assert property (@(posedge clk) disable iff (!rst_n)
    (zer[0] && !any_nan && !any_inf && !mismatch) |=> (result == $past(op_b)));

  // R5: a rounding carry leaves a power-of-two mantissa
  a_r5_round_carry: assert property (@(posedge clk) disable iff (!rst_n)
    (path_normal && round_carry && !overflow_hit) |=> (result[FRAC_W-1:0] == '0));
endmodule

// File: tb/fp32_same_sign_adder_test.sv
`timescale 1ns/1ps
module fp32_same_sign_adder_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] op_a = '0, op_b = '0;
  logic [31:0] result;
  logic        overflow, unsupported;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  fp32_same_sign_adder uut (
    .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b),
    .result(result), .overflow(overflow), .unsupported(unsupported)
  );

  localparam logic [31:0] QN = 32'h7FC00000;

  // reference: {unsupported, overflow, result} by exact integer arithmetic
  function automatic logic [33:0] model(input logic [31:0] a, input logic [31:0] b);
    logic [7:0]  ea, eb, e_hi, e_lo;
    logic [22:0] fa, fb;
    logic        uns, s;
    logic [63:0] m_hi, m_lo, exact, q, rem, half;
    int          d, p, k, e;
    logic [31:0] hi_word;
    ea = a[30:23]; eb = b[30:23]; fa = a[22:0]; fb = b[22:0];
    uns = a[31] ^ b[31];
    s = a[31];
    if ((ea == 8'hFF && fa != 0) || (eb == 8'hFF && fb != 0) || uns) return {uns, 1'b0, QN};
    if (ea == 8'hFF) return {2'b00, a};
    if (eb == 8'hFF) return {2'b00, b};
    if (ea == 0) return {2'b00, b};
    if (eb == 0) return {2'b00, a};
    if (ea >= eb) begin
      e_hi = ea; e_lo = eb; m_hi = {40'd1, fa}; m_lo = {40'd1, fb}; hi_word = a;
    end else begin
      e_hi = eb; e_lo = ea; m_hi = {40'd1, fb}; m_lo = {40'd1, fa}; hi_word = b;
    end
    d = int'(e_hi) - int'(e_lo);
    if (d >= 40) return {2'b00, hi_word};
    exact = (m_hi << d) + m_lo;
    p = 0;
    for (int i = 63; i >= 0; i--) if (exact[i] && p == 0) p = i;
    k = p - 23;
    e = int'(e_lo) + k;
    q = exact >> k;
    if (k > 0) begin
      rem  = exact & ((64'd1 << k) - 64'd1);
      half = 64'd1 << (k - 1);
      if (rem > half || (rem == half && q[0])) q = q + 64'd1;
    end
    if (q[24]) begin q = q >> 1; e = e + 1; end
    if (e >= 255) return {2'b01, s, 8'hFF, 23'd0};
    return {2'b00, s, e[7:0], q[22:0]};
  endfunction

  task automatic apply(input logic [31:0] a, input logic [31:0] b,
                       input logic [31:0] exp_res, input logic exp_ovf,
                       input logic exp_uns, input string req);
    @(negedge clk);
    op_a = a; op_b = b;
    @(posedge clk);
    #1;
    checks++;
    if (result !== exp_res || overflow !== exp_ovf || unsupported !== exp_uns) begin
      errors++;
      $display("FAIL %s: a=%h b=%h actual res=%h ovf=%b uns=%b expected res=%h ovf=%b uns=%b",
               req, a, b, result, overflow, unsupported, exp_res, exp_ovf, exp_uns);
    end
  endtask

  task automatic apply_model(input logic [31:0] a, input logic [31:0] b, input string req);
    logic [33:0] m;
    m = model(a, b);
    apply(a, b, m[31:0], m[32], m[33], req);
  endtask

  function automatic logic [31:0] rand_word(input int cls, input logic s, input logic [7:0] e);
    logic [22:0] f;
    f = 23'($urandom);
    case (cls)
      0: return {s, e, f};
      1: return {s, 8'h00, 23'd0};
      2: return {s, 8'hFF, 23'd0};
      3: return {s, 8'hFF, f | 23'd1};
      default: return {s, 8'h00, f | 23'd1};
    endcase
  endfunction

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] seed_sink;
    seed_sink = $urandom(32'd20240611);
    repeat (3) @(posedge clk);
    #1;
    checks++;
    if (result !== 32'd0 || overflow !== 1'b0 || unsupported !== 1'b0) begin
      errors++;
      $display("FAIL R11: actual res=%h ovf=%b uns=%b expected 0/0/0", result, overflow, unsupported);
    end
    @(negedge clk) rst_n = 1'b1;

    apply(32'h3FC00000, 32'h40500000, 32'h40980000, 0, 0, "R1 basic sum");
    apply(32'h40500000, 32'h3FC00000, 32'h40980000, 0, 0, "R2 swapped order");
    apply(32'h3FC00000, 32'h3FC00000, 32'h40400000, 0, 0, "R3 carry renormalize");
    apply(32'h3F800000, 32'h33800000, 32'h3F800000, 0, 0, "R4 tie to even down");
    apply(32'h3F800001, 32'h33800000, 32'h3F800002, 0, 0, "R4 tie to even up");
    apply(32'h3FFFFFFF, 32'h33800000, 32'h40000000, 0, 0, "R5 rounding carry");
    apply(32'h7F7FFFFF, 32'h7F7FFFFF, 32'h7F800000, 1, 0, "R6 positive overflow");
    apply(32'hFF7FFFFF, 32'hFF7FFFFF, 32'hFF800000, 1, 0, "R6 negative overflow");
    apply(32'h7F800001, 32'h3F800000, QN, 0, 0, "R7 NaN on A");
    apply(32'hBF800000, 32'hFFC12345, QN, 0, 0, "R7 NaN on B");
    apply(32'h7F800000, 32'h3F800000, 32'h7F800000, 0, 0, "R8 inf plus finite");
    apply(32'h3F800000, 32'h7F800000, 32'h7F800000, 0, 0, "R8 finite plus inf");
    apply(32'hFF800000, 32'hFF800000, 32'hFF800000, 0, 0, "R8 inf plus inf");
    apply(32'h00000000, 32'h40490FDB, 32'h40490FDB, 0, 0, "R9 zero A");
    apply(32'h40490FDB, 32'h00000000, 32'h40490FDB, 0, 0, "R9 zero B");
    apply(32'h80000000, 32'hC0000000, 32'hC0000000, 0, 0, "R9 negative zero");
    apply(32'h00000005, 32'h3F800000, 32'h3F800000, 0, 0, "R9 exponent-zero operand");
    apply(32'h3F800000, 32'hBF800000, QN, 0, 1, "R10 sign mismatch");
    apply(32'h80000000, 32'h7F800000, QN, 0, 1, "R10 mismatch with inf");
    apply(32'h4F000000, 32'h3F800000, 32'h4F000000, 0, 0, "R12 large gap");
    apply(32'h3F800000, 32'h4C7FFFFF, 32'h4C7FFFFF, 0, 0, "R12 gap of 25");

    // R1 R2 R3 R4 R5 R6: random same-sign normal pairs
    for (int n = 0; n < 3000; n++) begin
      logic s;
      int ea, eb;
      logic [31:0] a, b;
      s  = 1'($urandom);
      ea = (n % 8 == 0) ? 240 + int'($urandom % 15) : 1 + int'($urandom % 254);
      eb = ea + int'($urandom % 61) - 30;
      if (eb < 1) eb = 1;
      if (eb > 254) eb = 254;
      a = rand_word(0, s, 8'(ea));
      b = rand_word(0, s, 8'(eb));
      apply_model(a, b, "R1 random normal");
      apply_model(b, a, "R2 random commuted");
    end

    // R7 R8 R9 R10: random mixes of value classes and signs
    for (int n = 0; n < 800; n++) begin
      logic [31:0] a, b;
      a = rand_word(int'($urandom % 5), 1'($urandom), 8'(1 + $urandom % 254));
      b = rand_word(int'($urandom % 5), 1'($urandom), 8'(1 + $urandom % 254));
      apply_model(a, b, "R7 R8 R9 R10 special mix");
    end

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule